// File: doc/BRIEF.md
# Immediate-Controlled Vector Lane Shuffle

This block permutes the elements of a 128-bit vector. The vector is cut into aligned groups of four consecutive elements. An 8-bit immediate holds four 2-bit selectors, and every group is rearranged by the same selectors. The element width is chosen per operation: bytes give four groups, halfwords give two groups, and words give one group.

A producer presents the source vector, the immediate, the format code and a valid strobe in one cycle. The result is registered and appears on the following clock edge with its own valid flag. When no operation is presented, the result register holds its last value. Reset is asserted asynchronously. It is released through a two-stage synchronizer inside the block.

Top module: `shf_lane_shuffle`

## Requirements
- R1: Result element i of a group takes the source element of that same group whose index (0 to 3) is held in immediate bits [2i+1:2i].
- R2: Every aligned group of four elements uses the same four selectors from the immediate, and no element crosses from one group into another.
- R3: Format code 2'b00 selects 8-bit elements (16 elements, 4 groups), 2'b01 selects 16-bit elements (8 elements, 2 groups), and 2'b10 selects 32-bit elements (4 elements, 1 group).
- R4: Element 0 occupies the least significant bits of the vector. Element k occupies bits [(k+1)*W-1 : k*W] for element width W.
- R5: Immediate 8'hE4 returns the source unchanged in every format.
- R6: Immediate 8'h1B reverses the order of the four elements inside each group.
- R7: Immediate 8'h00 copies element 0 of each group to all four of its positions. Immediate 8'hFF copies element 3 of each group in the same way.
- R8: Format code 2'b11 returns the source unchanged, whatever the immediate.
- R9: An operation sampled with in_valid high at a rising edge appears on out_data, with out_valid high, right after that edge.
- R10: A rising edge with in_valid low drives out_valid low and leaves out_data unchanged.
- R11: While rst_n is low, and for two rising edges after it goes high, out_valid and out_data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_fmt | input | 2 | Element format code |
| in_imm | input | 8 | Four 2-bit element selectors |
| in_src | input | 128 | Source vector |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_data | output | 128 | Registered shuffled vector |

## Verification
The bench builds the block with its default parameters: a 128-bit vector, 8-bit immediate and groups of four. With these values every one of the 256 immediates can be applied in each of the three formats, on fresh random data each time. Every operation is then compared against a behavioural model. The unused format code, idle cycles with a changing source, and the synchronized reset release are driven as well. These show that the result holds, passes through unchanged, and stays cleared in those cases.

// File: rtl/shf_pkg.sv
package shf_pkg;
  localparam int unsigned VEC_W   = 128;
  localparam int unsigned GRP_N   = 4;
  localparam int unsigned SEL_W   = $clog2(GRP_N);
  localparam int unsigned IMM_W   = SEL_W * GRP_N;
  localparam int unsigned FMT_W   = 2;
  localparam int unsigned BASE_EW = 8;

  typedef enum logic [FMT_W-1:0] {
    FMT_BYTE = 2'b00,
    FMT_HALF = 2'b01,
    FMT_WORD = 2'b10,
    FMT_NONE = 2'b11
  } shf_fmt_e;
endpackage

// File: rtl/shf_rst_sync.sv
module shf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/shf_perm_net.sv
module shf_perm_net #(
  parameter int unsigned VEC_W  = 128,
  parameter int unsigned ELEM_W = 8,
  parameter int unsigned GRP_N  = 4,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned IMM_W  = SEL_W * GRP_N
) (
  input  logic [VEC_W-1:0] src,
  input  logic [IMM_W-1:0] imm,
  output logic [VEC_W-1:0] dst
);
  localparam int unsigned NUM_E = VEC_W / ELEM_W;

  for (genvar e = 0; e < NUM_E; e++) begin : g_elem
    localparam int unsigned BASE = (e / GRP_N) * GRP_N;
    localparam int unsigned POS  = e % GRP_N;

    logic [ELEM_W-1:0] lane [GRP_N];
    logic [SEL_W-1:0]  sel;

    for (genvar k = 0; k < GRP_N; k++) begin : g_lane
      assign lane[k] = src[(BASE+k)*ELEM_W +: ELEM_W];
    end

    assign sel = imm[POS*SEL_W +: SEL_W];
    assign dst[e*ELEM_W +: ELEM_W] = lane[sel];
  end
endmodule

// File: rtl/shf_lane_shuffle.sv
module shf_lane_shuffle
  import shf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [FMT_W-1:0]   in_fmt,
  input  logic [IMM_W-1:0]   in_imm,
  input  logic [VEC_W-1:0]   in_src,
  output logic               out_valid,
  output logic [VEC_W-1:0]   out_data
);
  localparam int unsigned NUM_FMT = 3;

  logic             rst_q_n;
  logic [VEC_W-1:0] perm [NUM_FMT];
  logic [VEC_W-1:0] data_d;
  logic [VEC_W-1:0] data_q;
  logic             vld_q;
  logic             data_en;
  shf_fmt_e         fmt;

  shf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  for (genvar f = 0; f < NUM_FMT; f++) begin : g_fmt
    shf_perm_net #(
      .VEC_W  (VEC_W),
      .ELEM_W (BASE_EW << f),
      .GRP_N  (GRP_N),
      .SEL_W  (SEL_W),
      .IMM_W  (IMM_W)
    ) u_perm (
      .src (in_src),
      .imm (in_imm),
      .dst (perm[f])
    );
  end

  assign fmt     = shf_fmt_e'(in_fmt);
  assign data_en = in_valid;

  always_comb begin
    case (fmt)
      FMT_BYTE: data_d = perm[0];
      FMT_HALF: data_d = perm[1];
      FMT_WORD: data_d = perm[2];
      default:  data_d = in_src;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (data_en) data_q <= data_d;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = data_q;
endmodule

// File: rtl/shf_lane_shuffle_chk.sv
module shf_lane_shuffle_chk (
  input logic         clk,
  input logic         rst_q_n,
  input logic         in_valid,
  input logic [1:0]   in_fmt,
  input logic [7:0]   in_imm,
  input logic [127:0] in_src,
  input logic         out_valid,
  input logic [127:0] out_data
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_q_n)
    in_valid |=> out_valid); // R9

  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> !out_valid); // R10

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_valid |=> $stable(out_data)); // R10

  AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_imm == 8'hE4) |=> out_data == $past(in_src)); // R5

  AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_fmt == 2'b11) |=> out_data == $past(in_src)); // R8

  AST_WORD_BCAST: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_fmt == 2'b10 && in_imm == 8'h00) |=> out_data == {4{$past(in_src[31:0])}}); // R7

  AST_WORD_REVERSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_valid && in_fmt == 2'b10 && in_imm == 8'h1B) |=>
      out_data == {$past(in_src[31:0]), $past(in_src[63:32]), $past(in_src[95:64]), $past(in_src[127:96])}); // R6
endmodule

bind shf_lane_shuffle shf_lane_shuffle_chk u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .in_valid  (in_valid),
  .in_fmt    (in_fmt),
  .in_imm    (in_imm),
  .in_src    (in_src),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/shf_lane_shuffle_bench.sv
`timescale 1ns/1ps
module shf_lane_shuffle_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   in_fmt;
  logic [7:0]   in_imm;
  logic [127:0] in_src;
  logic         out_valid;
  logic [127:0] out_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic         exp_valid;
  logic [127:0] exp_data;
  string        exp_tag;

  shf_lane_shuffle u_shf_lane_shuffle (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_fmt    (in_fmt),
    .in_imm    (in_imm),
    .in_src    (in_src),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Behavioural model of R1..R4 and R8
  function automatic logic [127:0] model(input logic [127:0] s, input logic [7:0] im,
                                         input logic [1:0] f);
    logic [127:0] r;
    int esz, ne;
    if (f == 2'b11) return s;
    esz = 8 << f;
    ne  = 128 / esz;
    r   = '0;
    for (int e = 0; e < ne; e++) begin
      int grp = (e / 4) * 4;
      int pick = (im >> (2 * (e % 4))) & 3;
      for (int b = 0; b < esz; b++) r[e*esz + b] = s[(grp + pick)*esz + b];
    end
    return r;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic compare();
    n_chk++;
    if (out_valid !== exp_valid || out_data !== exp_data) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b data=%h expected valid=%0b data=%h",
               exp_tag, out_valid, out_data, exp_valid, exp_data);
    end
  endtask

  task automatic apply(input logic v, input logic [1:0] f, input logic [7:0] im,
                       input logic [127:0] s, input string tag, input logic [127:0] direct,
                       input bit use_direct);
    @(negedge clk);
    compare();
    in_valid = v; in_fmt = f; in_imm = im; in_src = s;
    exp_tag  = tag;
    exp_valid = v;
    if (v) exp_data = use_direct ? direct : model(s, im, f);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_fmt = '0; in_imm = '0; in_src = '0;
    exp_valid = 1'b0; exp_data = '0; exp_tag = "R11 reset";
    repeat (3) begin
      @(negedge clk);
      compare(); // R11 during reset
      in_src = rnd128();
    end
    rst_n = 1'b1;
    // R11: two synchronizer edges after release, plus idle
    for (int i = 0; i < 3; i++) apply(1'b0, 2'b00, 8'hE4, rnd128(), "R11 post-release", '0, 0);

    // R1 R2 R3 R4 R9: every immediate in every format
    for (int f = 0; f < 3; f++)
      for (int im = 0; im < 256; im++)
        apply(1'b1, f[1:0], im[7:0], rnd128(), "R1/R2/R3/R4/R9 sweep", '0, 0);

    // R5 identity, direct expectation
    for (int f = 0; f < 3; f++) begin
      logic [127:0] s = rnd128();
      apply(1'b1, f[1:0], 8'hE4, s, "R5 identity", s, 1);
    end

    // R6 reverse, direct expectation per format
    begin
      logic [127:0] s = rnd128();
      logic [127:0] r;
      for (int e = 0; e < 16; e++) r[e*8 +: 8] = s[((e/4)*4 + 3 - e%4)*8 +: 8];
      apply(1'b1, 2'b00, 8'h1B, s, "R6 byte reverse", r, 1);
      for (int e = 0; e < 8; e++) r[e*16 +: 16] = s[((e/4)*4 + 3 - e%4)*16 +: 16];
      apply(1'b1, 2'b01, 8'h1B, s, "R6 half reverse", r, 1);
      r = {s[31:0], s[63:32], s[95:64], s[127:96]};
      apply(1'b1, 2'b10, 8'h1B, s, "R6 word reverse", r, 1);
    end

    // R7 broadcasts
    begin
      logic [127:0] s = rnd128();
      apply(1'b1, 2'b10, 8'h00, s, "R7 word bcast0", {4{s[31:0]}}, 1);
      apply(1'b1, 2'b10, 8'hFF, s, "R7 word bcast3", {4{s[127:96]}}, 1);
      apply(1'b1, 2'b01, 8'h00, s, "R7 half bcast0", {{4{s[79:64]}}, {4{s[15:0]}}}, 1);
      apply(1'b1, 2'b00, 8'hFF, s, "R7 byte bcast3",
            {{4{s[127:120]}}, {4{s[95:88]}}, {4{s[63:56]}}, {4{s[31:24]}}}, 1);
    end

    // R8 unused format passes through
    for (int i = 0; i < 8; i++) begin
      logic [127:0] s = rnd128();
      apply(1'b1, 2'b11, 8'(i * 37), s, "R8 pass-through", s, 1);
    end

    // R10 idle cycles hold the result while inputs change
    apply(1'b1, 2'b00, 8'h4E, rnd128(), "R9 load before idle", '0, 0);
    for (int i = 0; i < 6; i++)
      apply(1'b0, 2'(i % 4), 8'($urandom), rnd128(), "R10 idle hold", '0, 0);
    apply(1'b1, 2'b01, 8'hB1, rnd128(), "R9 resume", '0, 0);
    apply(1'b0, 2'b00, 8'h00, '0, "R10 idle after resume", '0, 0);

    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule